// File: doc/BRIEF.md
# Per-Wavelength Card Matching Scheduler

This block decides, once per time slot, which destination card each input port of a multi-card optical fabric may reach. Every card carries one input port per wavelength; by the time this block runs, a local step on each card has already tied every input port to a wavelength. The wavelength fixes the receiving port inside the destination card, so the only thing left to choose is the card. Two ports that carry the same wavelength and aim at the same card would land on one receiver, and only one of them can win.

The matching is split into N independent planes, one per wavelength. Each plane is an M-by-M match between source cards and destination cards. It runs a round-robin request, grant and accept exchange for a fixed number of iterations, one iteration per clock. Each destination card keeps a grant pointer and each source card keeps an accept pointer per plane. The result is a grant flag and a card index per port, plus a one-hot gate enable per port that drives the amplifier gates of that port's 1-by-M space switch.

Control is a plain strobe pair with no back-pressure. A `start` pulse is taken only when the block is idle; it latches all port inputs for that slot. `done` pulses once when the new result is on the outputs. A `start` raised while a slot is still running is dropped, so the caller paces slots by waiting for `done`.

Top module: `wl_card_match`

## Requirements
- R1: While reset is held and right after it is released, `done`, every `grant` bit, every `grant_card` field and every `gate_en` bit are 0; all pointers restart at 0.
- R2: `start` is taken only while idle, and all port inputs are latched at that edge. `done` is high for exactly one cycle, which follows the third rising edge after the taking edge, and the new results appear in that same cycle. A `start` raised during the three edges of a running slot is ignored, and input changes after the taking edge do not affect that slot.
- R3: A port is granted card j only when bit j of its destination vector `port_dst[p*M +: M]` was set in the latched inputs. Port index p equals card*N + local port.
- R4: In any result, no two granted ports carry the same wavelength towards the same destination card.
- R5: A port is eligible only when `port_vld[p]` is 1, its wavelength `port_wl[p*W +: W]` is below N, and no lower-numbered port on the same card holds that wavelength with both conditions also true. An ineligible port is never granted.
- R6: An eligible port with a requested card that no other eligible port on its wavelength requests is always granted.
- R7: Each destination card grants the requesting source card found first at or after its grant pointer, counting upward with wrap-around. Each source card accepts the offering destination card found first at or after its accept pointer. A pointer moves to one past its partner only when the grant is accepted in the first iteration of a slot.
- R8: Iterations two and three match only still-unmatched source and destination cards within a plane; matches made earlier in the slot are kept.
- R9: `gate_en[p*M + j]` is 1 exactly when port p is granted and its `grant_card[p*C +: C]` equals j; all other gate bits are 0.
- R10: Planes are independent: ports on different wavelengths may be granted the same destination card in the same slot.
- R11: `grant`, `grant_card` and `gate_en` change only in the cycle in which `done` is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a slot; ignored while a slot runs |
| port_vld | input | M*N | Per-port flag: wavelength assignment is valid |
| port_wl | input | M*N*W | Per-port wavelength, W = ceil(log2 N), minimum 1 |
| port_dst | input | M*N*M | Per-port vector of destination cards with waiting packets |
| done | output | 1 | One-cycle pulse: new result on the outputs |
| grant | output | M*N | Per-port grant flag |
| grant_card | output | M*N*C | Per-port chosen card, C = ceil(log2 M), minimum 1; 0 when not granted |
| gate_en | output | M*N*M | Per-port one-hot switch gate enables |

## Verification
A slot taken at rising edge E0 runs its iterations on E1, E2 and E3, so `done`, `grant`, `grant_card` and `gate_en` all change together at E3. The bench drives every input on falling edges and reads every output on falling edges. It expects `done` low after E1 and E2 and high after E3, and it compares the grant, card and gate fields only after the falling edge that follows E3. Pointer behaviour is checked across back-to-back slots after a fresh reset, so the expected winners follow from the reset pointers alone. The hold and ignored-start cases are read a few falling edges after the inputs change.

// File: rtl/wlm_pkg.sv
`timescale 1ns/1ps
package wlm_pkg;

  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_RUN  = 1'b1
  } slot_state_t;

  // Width of an index into n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wlm_rr_pick.sv
`timescale 1ns/1ps
// Round-robin pick: first set bit at or after ptr, with wrap-around.
module wlm_rr_pick #(
  parameter int W  = 4,
  parameter int PW = wlm_pkg::idx_w(W)
) (
  input  logic [W-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [W-1:0]  gnt
);

  always_comb begin
    logic hit;
    int   idx;
    gnt = '0;
    hit = 1'b0;
    idx = 0;
    for (int k = 0; k < W; k++) begin
      idx = (int'(ptr) + k) % W;
      if (!hit && req[idx]) begin
        gnt[idx] = 1'b1;
        hit      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wlm_plane.sv
`timescale 1ns/1ps
// One wavelength plane: iterative source-card to destination-card match.
module wlm_plane #(
  parameter int M  = 4,
  parameter int CW = wlm_pkg::idx_w(M)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           first,
  input  logic [M*M-1:0] req_in,
  output logic [M-1:0]   nxt_match,
  output logic [CW-1:0]  nxt_card [M]
);

  logic [M*M-1:0] req_q;
  logic [M-1:0]   in_m;
  logic [M-1:0]   out_m;
  logic [CW-1:0]  card_q [M];
  logic [CW-1:0]  gptr   [M];
  logic [CW-1:0]  aptr   [M];

  logic [M-1:0]   cand_col  [M];  // [dst][src]
  logic [M-1:0]   gnt_col   [M];  // [dst][src]
  logic [M-1:0]   offer_row [M];  // [src][dst]
  logic [M-1:0]   acc_row   [M];  // [src][dst]
  logic [M-1:0]   acc_any;
  logic [CW-1:0]  acc_idx   [M];
  logic [M-1:0]   out_hit;

  function automatic logic [CW-1:0] bump(input int v);
    if (v + 1 >= M) return '0;
    return CW'(v + 1);
  endfunction

  // Requests that are still open this iteration.
  always_comb begin
    for (int j = 0; j < M; j++)
      for (int i = 0; i < M; i++)
        cand_col[j][i] = req_q[i*M + j] & ~in_m[i] & ~out_m[j];
  end

  generate
    for (genvar j = 0; j < M; j++) begin : g_grant
      wlm_rr_pick #(.W(M), .PW(CW)) u_gnt (
        .req (cand_col[j]),
        .ptr (gptr[j]),
        .gnt (gnt_col[j])
      );
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        offer_row[i][j] = gnt_col[j][i];
  end

  generate
    for (genvar i = 0; i < M; i++) begin : g_accept
      wlm_rr_pick #(.W(M), .PW(CW)) u_acc (
        .req (offer_row[i]),
        .ptr (aptr[i]),
        .gnt (acc_row[i])
      );
    end
  endgenerate

  always_comb begin
    out_hit = '0;
    for (int i = 0; i < M; i++) begin
      acc_any[i] = |acc_row[i];
      acc_idx[i] = '0;
      for (int j = 0; j < M; j++) begin
        if (acc_row[i][j]) acc_idx[i] = CW'(j);
        out_hit[j] = out_hit[j] | acc_row[i][j];
      end
      nxt_match[i] = in_m[i] | acc_any[i];
      nxt_card[i]  = acc_any[i] ? acc_idx[i] : card_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      in_m  <= '0;
      out_m <= '0;
      for (int i = 0; i < M; i++) begin
        card_q[i] <= '0;
        gptr[i]   <= '0;
        aptr[i]   <= '0;
      end
    end else if (load) begin
      req_q <= req_in;
      in_m  <= '0;
      out_m <= '0;
    end else if (step) begin
      in_m  <= nxt_match;
      out_m <= out_m | out_hit;
      for (int i = 0; i < M; i++) begin
        if (acc_any[i]) begin
          card_q[i] <= acc_idx[i];
          if (first) begin
            aptr[i]          <= bump(int'(acc_idx[i]));
            gptr[acc_idx[i]] <= bump(i);
          end
        end
      end
    end
  end

endmodule

// File: rtl/wlm_slot_ctrl.sv
`timescale 1ns/1ps
// Slot sequencer: take start, run ITERS iteration steps, pulse done.
module wlm_slot_ctrl import wlm_pkg::*; #(
  parameter int ITERS = 3,
  parameter int IW    = idx_w(ITERS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic first,
  output logic last,
  output logic done
);

  slot_state_t   st;
  logic [IW-1:0] cnt;

  assign load  = start && (st == SLOT_IDLE);
  assign step  = (st == SLOT_RUN);
  assign first = step && (cnt == '0);
  assign last  = step && (cnt == IW'(ITERS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SLOT_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        st  <= SLOT_RUN;
        cnt <= '0;
      end else if (last) begin
        st <= SLOT_IDLE;
      end else if (step) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wl_card_match.sv
`timescale 1ns/1ps
// Per-wavelength card matching scheduler (top).
module wl_card_match import wlm_pkg::*; #(
  parameter int M     = 4,
  parameter int N     = 3,
  parameter int ITERS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [M*N-1:0]             port_vld,
  input  logic [M*N*idx_w(N)-1:0]    port_wl,
  input  logic [M*N*M-1:0]           port_dst,
  output logic                       done,
  output logic [M*N-1:0]             grant,
  output logic [M*N*idx_w(M)-1:0]    grant_card,
  output logic [M*N*M-1:0]           gate_en
);

  localparam int P  = M * N;
  localparam int CW = idx_w(M);
  localparam int WW = idx_w(N);

  logic load, step, first, last;

  wlm_slot_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .first (first),
    .last  (last),
    .done  (done)
  );

  // Eligibility and per-plane request matrices from the live inputs.
  logic [P-1:0]   elig;
  logic [M*M-1:0] plane_req [N];

  always_comb begin
    elig = '0;
    for (int w = 0; w < N; w++) plane_req[w] = '0;
    for (int c = 0; c < M; c++) begin
      logic [N-1:0] taken;
      taken = '0;
      for (int n = 0; n < N; n++) begin
        int p;
        int wl;
        p  = c * N + n;
        wl = int'(port_wl[p*WW +: WW]);
        if (port_vld[p] && wl < N) begin
          if (!taken[wl]) begin
            taken[wl] = 1'b1;
            elig[p]   = 1'b1;
            plane_req[wl][c*M +: M] = port_dst[p*M +: M];
          end
        end
      end
    end
  end

  logic [M-1:0]  pl_match [N];
  logic [CW-1:0] pl_card  [N][M];

  generate
    for (genvar w = 0; w < N; w++) begin : g_plane
      wlm_plane #(.M(M), .CW(CW)) u_plane (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .first     (first),
        .req_in    (plane_req[w]),
        .nxt_match (pl_match[w]),
        .nxt_card  (pl_card[w])
      );
    end
  endgenerate

  // Latched slot inputs.
  logic [P-1:0]    own_q;
  logic [P*WW-1:0] wl_q;
  logic [P*M-1:0]  dst_q;

  // Map plane results back to ports.
  logic [P-1:0]  res_g;
  logic [CW-1:0] res_c [P];

  always_comb begin
    for (int p = 0; p < P; p++) begin
      int wl;
      wl       = int'(wl_q[p*WW +: WW]);
      res_g[p] = 1'b0;
      res_c[p] = '0;
      if (own_q[p] && wl < N) begin
        if (pl_match[wl][p / N]) begin
          res_g[p] = 1'b1;
          res_c[p] = pl_card[wl][p / N];
        end
      end
    end
  end

  logic [P-1:0]  grant_q;
  logic [CW-1:0] card_q [P];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '0;
      wl_q    <= '0;
      dst_q   <= '0;
      grant_q <= '0;
      for (int p = 0; p < P; p++) card_q[p] <= '0;
    end else begin
      if (load) begin
        own_q <= elig;
        wl_q  <= port_wl;
        dst_q <= port_dst;
      end
      if (last) begin
        grant_q <= res_g;
        for (int p = 0; p < P; p++) card_q[p] <= res_c[p];
      end
    end
  end

  assign grant = grant_q;

  always_comb begin
    for (int p = 0; p < P; p++) begin
      grant_card[p*CW +: CW] = card_q[p];
      for (int j = 0; j < M; j++)
        gate_en[p*M + j] = grant_q[p] && (card_q[p] == CW'(j));
    end
  end

endmodule

// File: rtl/wl_card_match_chk.sv
`timescale 1ns/1ps
// Property checker for wl_card_match, attached by bind below.
module wl_card_match_chk #(
  parameter int M = 4,
  parameter int N = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             done,
  input logic [M*N-1:0]                   grant,
  input logic [M*N*wlm_pkg::idx_w(M)-1:0] grant_card,
  input logic [M*N-1:0]                   own_q,
  input logic [M*N*wlm_pkg::idx_w(N)-1:0] wl_q,
  input logic [M*N*M-1:0]                 dst_q
);

  localparam int P  = M * N;
  localparam int CW = wlm_pkg::idx_w(M);
  localparam int WW = wlm_pkg::idx_w(N);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(grant) && $stable(grant_card)));

  generate
    for (genvar p = 0; p < P; p++) begin : g_port
      // R3
      req_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && grant[p]) |-> dst_q[p*M + int'(grant_card[p*CW +: CW])]);

      // R5
      elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && grant[p]) |-> own_q[p]);

      for (genvar q = p + 1; q < P; q++) begin : g_pair
        localparam bit SAME_CARD = ((p / N) == (q / N));
        // R4
        rx_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (done && grant[p] && grant[q] &&
           (wl_q[p*WW +: WW] == wl_q[q*WW +: WW]))
          |-> (!SAME_CARD &&
               (grant_card[p*CW +: CW] != grant_card[q*CW +: CW])));
      end
    end
  endgenerate

endmodule

bind wl_card_match wl_card_match_chk #(.M(M), .N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .grant      (grant),
  .grant_card (grant_card),
  .own_q      (own_q),
  .wl_q       (wl_q),
  .dst_q      (dst_q)
);

// File: tb/sim_wl_card_match.sv
`timescale 1ns/1ps
module sim_wl_card_match;

  localparam int M  = 4;
  localparam int N  = 3;
  localparam int P  = M * N;
  localparam int CW = 2;
  localparam int WW = 2;

  logic            clk   = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [P-1:0]    port_vld;
  logic [P*WW-1:0] port_wl;
  logic [P*M-1:0]  port_dst;
  logic            done;
  logic [P-1:0]    grant;
  logic [P*CW-1:0] grant_card;
  logic [P*M-1:0]  gate_en;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit eg [P];
  int ec [P];

  always #2.5 clk = ~clk;

  wl_card_match #(.M(M), .N(N), .ITERS(3)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .port_vld   (port_vld),
    .port_wl    (port_wl),
    .port_dst   (port_dst),
    .done       (done),
    .grant      (grant),
    .grant_card (grant_card),
    .gate_en    (gate_en)
  );

  // One active port of a table row and its expected result.
  typedef struct packed {
    logic       en;
    logic       v;
    logic [3:0] p;
    logic [1:0] wl;
    logic [3:0] dst;
    logic       eg;
    logic [1:0] ec;
  } lane_t;

  localparam int NV = 6;
  localparam lane_t VT [NV][4] = '{
    // lone requests on three planes
    '{'{1'b1, 1'b1, 4'd0, 2'd0, 4'b0100, 1'b1, 2'd2},
      '{1'b1, 1'b1, 4'd4, 2'd1, 4'b1000, 1'b1, 2'd3},
      '{1'b1, 1'b1, 4'd7, 2'd2, 4'b0000, 1'b0, 2'd0}, '0},
    // two cards on plane 0 fight for card 2; plane 1 also takes card 2
    '{'{1'b1, 1'b1, 4'd0, 2'd0, 4'b0100, 1'b1, 2'd2},
      '{1'b1, 1'b1, 4'd3, 2'd0, 4'b0100, 1'b0, 2'd0},
      '{1'b1, 1'b1, 4'd6, 2'd1, 4'b0100, 1'b1, 2'd2}, '0},
    // second iteration fills the leftover pair
    '{'{1'b1, 1'b1, 4'd0, 2'd0, 4'b0011, 1'b1, 2'd0},
      '{1'b1, 1'b1, 4'd3, 2'd0, 4'b0011, 1'b1, 2'd1}, '0, '0},
    // out-of-range wavelength, invalid flag, one good port
    '{'{1'b1, 1'b1, 4'd1,  2'd3, 4'b0010, 1'b0, 2'd0},
      '{1'b1, 1'b0, 4'd9,  2'd0, 4'b0010, 1'b0, 2'd0},
      '{1'b1, 1'b1, 4'd10, 2'd2, 4'b0001, 1'b1, 2'd0}, '0},
    // same wavelength twice on card 0: lower port wins the slot
    '{'{1'b1, 1'b1, 4'd0, 2'd1, 4'b0010, 1'b1, 2'd1},
      '{1'b1, 1'b1, 4'd1, 2'd1, 4'b0100, 1'b0, 2'd0}, '0, '0},
    // three cards, three targets: needs all three iterations
    '{'{1'b1, 1'b1, 4'd0, 2'd0, 4'b0111, 1'b1, 2'd0},
      '{1'b1, 1'b1, 4'd3, 2'd0, 4'b0111, 1'b1, 2'd1},
      '{1'b1, 1'b1, 4'd6, 2'd0, 4'b0111, 1'b1, 2'd2}, '0}
  };

  function automatic string row_tag(input int k);
    case (k)
      0:       return "R3 R6";
      1:       return "R4 R10";
      2:       return "R8";
      3:       return "R5";
      4:       return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    port_vld = '0;
    port_wl  = '0;
    port_dst = '0;
    for (int p = 0; p < P; p++) begin
      eg[p] = 1'b0;
      ec[p] = 0;
    end
  endtask

  task automatic put(input int p, input bit v, input int wl, input int dst,
                     input bit g, input int c);
    port_vld[p]          = v;
    port_wl[p*WW +: WW]  = WW'(wl);
    port_dst[p*M +: M]   = M'(dst);
    eg[p]                = g;
    ec[p]                = c;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Start pulse taken at E0; done due after E3.
  task automatic run_slot();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(done == 1'b0, "R2", "done before third edge", int'(done), 0);
    end
    @(negedge clk);
    check(done == 1'b1, "R2", "done after third edge", int'(done), 1);
  endtask

  task automatic check_out(input string req);
    for (int p = 0; p < P; p++) begin
      check(grant[p] == eg[p], req, $sformatf("grant port %0d", p),
            int'(grant[p]), int'(eg[p]));
      if (eg[p])
        check(int'(grant_card[p*CW +: CW]) == ec[p], req,
              $sformatf("card port %0d", p),
              int'(grant_card[p*CW +: CW]), ec[p]);
      for (int j = 0; j < M; j++) begin
        bit ge;
        ge = eg[p] && (ec[p] == j);
        check(gate_en[p*M + j] == ge, "R9",
              $sformatf("gate port %0d card %0d", p, j),
              int'(gate_en[p*M + j]), int'(ge));
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(grant == '0, "R1", "grant in reset", int'(grant), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state after release
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    check(grant_card == '0, "R1", "cards after reset", int'(grant_card), 0);
    check(gate_en == '0, "R1", "gates after reset", int'(gate_en != '0), 0);

    // Table of slots, each from reset pointers.
    for (int k = 0; k < NV; k++) begin
      do_reset();
      clear_all();
      for (int l = 0; l < 4; l++)
        if (VT[k][l].en)
          put(int'(VT[k][l].p), VT[k][l].v, int'(VT[k][l].wl),
              int'(VT[k][l].dst), VT[k][l].eg, int'(VT[k][l].ec));
      run_slot();
      check_out(row_tag(k));
    end

    // R7: grant pointer rotates across slots
    do_reset();
    clear_all();
    put(0, 1'b1, 0, 4'b0100, 1'b1, 2);
    put(3, 1'b1, 0, 4'b0100, 1'b0, 0);
    run_slot();
    check_out("R7");
    eg[0] = 1'b0; eg[3] = 1'b1; ec[3] = 2;
    run_slot();
    check_out("R7");
    eg[0] = 1'b1; ec[0] = 2; eg[3] = 1'b0;
    run_slot();
    check_out("R7");

    // R7: accept pointer rotates across slots
    do_reset();
    clear_all();
    put(0, 1'b1, 0, 4'b0110, 1'b1, 1);
    run_slot();
    check_out("R7");
    ec[0] = 2;
    run_slot();
    check_out("R7");
    ec[0] = 1;
    run_slot();
    check_out("R7");

    // R2: start held while busy is ignored; inputs latched at start
    do_reset();
    clear_all();
    put(0, 1'b1, 0, 4'b0100, 1'b1, 2);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    port_dst[3:0] = 4'b1000;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2", "done while busy", int'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R2", "done after busy start", int'(done), 1);
    repeat (4) begin
      @(negedge clk);
      check(done == 1'b0, "R2", "no extra slot", int'(done), 0);
    end
    check_out("R2");

    // R11: outputs hold without a new slot
    port_vld = '1;
    port_dst = '1;
    repeat (5) @(negedge clk);
    check(done == 1'b0, "R11", "done idle", int'(done), 0);
    check_out("R11");

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule